// File: doc/BRIEF.md
# Framer Alarm Interrupt Register Bank

This block collects per-frame alarm events from the receive side of a T1/E1 framer and turns changes of alarm state into sticky status bits. It currently serves two sources: the receive bipolar-violation flag and the receive loss-of-signal flag. A frame boundary strobe closes each frame. The alarm level of a source for that frame is "at least one event seen during the frame". Whenever that level differs from the level of the previous frame, the source's status bit latches to 1. This happens on both rising and falling alarms.

A synchronous processor port reads and writes four byte-wide registers. The registers are a clear-mode control register, a block-level interrupt gate, the status register and the per-source enable register. The single interrupt output is registered. It is high when any latched status bit has its per-source enable set and the block gate is open. A run-time control bit selects how status is cleared: clear-on-read, or write-one-to-clear.

Top module: `frm_alarm_irq_bank`

## Requirements
- R1: A synchronous active-low reset sets every register to read 0 and drives `irq` low. The clear mode returns to write-one-to-clear (control bit 0 = 0).
- R2: At a cycle with `frame_tick` high, a source's level is the OR of its events over the frame, including the tick cycle. The source's status bit is set at that edge when this level differs from the previous frame's level, on both assertion and deassertion. Status bit 3 at 0x0B02 is bipolar violation and status bit 4 is loss of signal.
- R3: Status bits latch even when the per-source enable or the block gate is 0.
- R4: `irq` is registered. One cycle after the register values, it equals OR over sources of (status bit AND enable bit at 0x0B03, same bit position), ANDed with bit 1 of 0x0B01.
- R5: With control bit 0 (address 0x0B00) = 0, writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R6: With control bit 0 = 1, a read of 0x0B02 clears the bits it returned, and writes to 0x0B02 have no effect.
- R7: A change detected in the same cycle as a clear (by write or by read) leaves the status bit set.
- R8: Reads of unmapped addresses and of unimplemented bits return 0. Writes to unmapped addresses change no register.
- R9: `cpu_rdata` reflects the addressed register combinationally in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | Last cycle of a receive frame |
| bpv_evt | input | 1 | Bipolar violation seen this cycle |
| los_evt | input | 1 | Loss of signal seen this cycle |
| cpu_addr | input | 16 | Register address |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt request, active high |

## Verification
A status change appears at the clock edge that ends its tick cycle, so it is visible on `cpu_rdata` in the next cycle. `irq` follows one further edge later, because it is registered from status, enables and gate. Read data is due in the same cycle as the address. A clear takes effect at the edge that ends the read or write cycle. The bench drives every operation half a cycle before its edge. It samples read data 1 ns after driving. It samples `irq` at the next falling edge, against a per-cycle reference model that applies each requirement after the edge.

// File: rtl/frm_alarm_pkg.sv
// Package: shared widths, register addresses and source bit positions for
// the framer alarm interrupt register bank.
package frm_alarm_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int NSRC   = 2;
    // Source order: 0 = bipolar violation, 1 = loss of signal.
    localparam int unsigned SRC_POS [NSRC] = '{3, 4};
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 16'h0B00;
    localparam logic [ADDR_W-1:0] ADDR_GATE = 16'h0B01;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 16'h0B02;
    localparam logic [ADDR_W-1:0] ADDR_ENAB = 16'h0B03;
    localparam int CTRL_RUR_BIT = 0;
    localparam int GATE_BIT     = 1;
endpackage

// File: rtl/frm_alarm_detect.sv
// Module: per-source frame alarm change detector.
// Accumulates events across one frame. On frame_tick it compares the
// frame's level with the previous frame's level and pulses chg when they
// differ. Assumes frame_tick is a single-cycle strobe.
module frm_alarm_detect #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_tick,
    input  logic [NSRC-1:0] evt,
    output logic [NSRC-1:0] chg
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic acc_q, prev_q, level;
        assign level  = acc_q | evt[i];
        assign chg[i] = frame_tick & (level ^ prev_q);
        // Accumulate within a frame; store the level at the frame end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q  <= 1'b0;
                prev_q <= 1'b0;
            end else if (frame_tick) begin
                acc_q  <= 1'b0;
                prev_q <= level;
            end else begin
                acc_q  <= level;
            end
        end
    end
endmodule

// File: rtl/frm_alarm_regs.sv
// Module: register file for control, gate, sticky status and enables.
// Assumes cpu_wr and cpu_rd are one-cycle strobes. Read data is a
// combinational function of cpu_addr. Set beats clear.
module frm_alarm_regs
    import frm_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   chg,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [NSRC-1:0]   stat_q,
    output logic [NSRC-1:0]   en_q,
    output logic              gate_q
);
    logic rur_q;
    logic sel_ctrl, sel_gate, sel_stat, sel_enab, mapped;
    logic [NSRC-1:0] clr;
    logic [DATA_W-1:0] stat_byte, en_byte;

    assign sel_ctrl = (cpu_addr == ADDR_CTRL);
    assign sel_gate = (cpu_addr == ADDR_GATE);
    assign sel_stat = (cpu_addr == ADDR_STAT);
    assign sel_enab = (cpu_addr == ADDR_ENAB);
    assign mapped   = sel_ctrl | sel_gate | sel_stat | sel_enab;

    for (genvar i = 0; i < NSRC; i++) begin : g_clr
        // Clear request per source according to the selected mode.
        assign clr[i] = rur_q ? (cpu_rd & sel_stat)
                              : (cpu_wr & sel_stat & cpu_wdata[SRC_POS[i]]);
    end

    // Control, gate and enable registers written by the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rur_q  <= 1'b0;
            gate_q <= 1'b0;
            en_q   <= '0;
        end else if (cpu_wr) begin
            if (sel_ctrl) rur_q  <= cpu_wdata[CTRL_RUR_BIT];
            if (sel_gate) gate_q <= cpu_wdata[GATE_BIT];
            if (sel_enab)
                for (int i = 0; i < NSRC; i++) en_q[i] <= cpu_wdata[SRC_POS[i]];
        end
    end

    // Sticky status: a detected change sets, a clear request resets.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= chg | (stat_q & ~clr);
    end

    // Place the per-source bits at their byte positions.
    always_comb begin
        stat_byte = '0;
        en_byte   = '0;
        for (int i = 0; i < NSRC; i++) begin
            stat_byte[SRC_POS[i]] = stat_q[i];
            en_byte[SRC_POS[i]]   = en_q[i];
        end
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        cpu_rdata = '0;
        if (sel_ctrl) cpu_rdata[CTRL_RUR_BIT] = rur_q;
        if (sel_gate) cpu_rdata[GATE_BIT]     = gate_q;
        if (sel_stat) cpu_rdata = stat_byte;
        if (sel_enab) cpu_rdata = en_byte;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chg[i] |=> stat_q[i]);
        // R5
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_wr && sel_stat && !rur_q && cpu_wdata[SRC_POS[i]] && !chg[i])
            |=> !stat_q[i]);
        // R6
        rur_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_rd && sel_stat && rur_q && !chg[i]) |=> !stat_q[i]);
    end

    // R8
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !mapped) |=> ($stable(en_q) && $stable(gate_q) && $stable(rur_q)));
endmodule

// File: rtl/frm_alarm_irq.sv
// Module: interrupt combiner.
// Registers the OR of enabled status bits, gated by the block-level enable.
module frm_alarm_irq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] stat,
    input  logic [NSRC-1:0] en,
    input  logic            gate,
    output logic            irq
);
    // Register the gated interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= gate & (|(stat & en));
    end

    // R4
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !irq);
    // R4
    no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & en) == '0) |=> !irq);
endmodule

// File: rtl/frm_alarm_irq_bank.sv
// Module: top of the framer alarm interrupt register bank.
// Connects the change detector, the register file and the interrupt combiner.
// Assumes events and strobes are synchronous to clk.
module frm_alarm_irq_bank
    import frm_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              bpv_evt,
    input  logic              los_evt,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              irq
);
    logic [NSRC-1:0] evt, chg, stat, en;
    logic gate;

    assign evt = {los_evt, bpv_evt};

    frm_alarm_detect #(.NSRC(NSRC)) i_detect (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .evt(evt), .chg(chg)
    );

    frm_alarm_regs i_regs (
        .clk(clk), .rst_n(rst_n), .chg(chg),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .stat_q(stat), .en_q(en), .gate_q(gate)
    );

    frm_alarm_irq #(.NSRC(NSRC)) i_irq (
        .clk(clk), .rst_n(rst_n), .stat(stat), .en(en), .gate(gate), .irq(irq)
    );
endmodule

// File: tb/test_frm_alarm_irq_bank.sv
`timescale 1ns/1ps
module test_frm_alarm_irq_bank;
    logic clk = 1'b0, rst_n = 1'b0;
    logic frame_tick = 0, bpv_evt = 0, los_evt = 0, cpu_wr = 0, cpu_rd = 0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0, cpu_rdata;
    logic irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    frm_alarm_irq_bank i_frm_alarm_irq_bank (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .bpv_evt(bpv_evt),
        .los_evt(los_evt), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
    );

    localparam logic [15:0] A_CTRL = 16'h0B00, A_GATE = 16'h0B01,
                            A_STAT = 16'h0B02, A_ENAB = 16'h0B03;

    // Reference model state
    logic m_accb, m_accl, m_prevb, m_prevl, m_rur, m_gate, m_irq;
    logic [7:0] m_stat, m_en;

    function automatic logic [7:0] rd_model(input logic [15:0] a);
        case (a)
            A_CTRL:  return {7'b0, m_rur};
            A_GATE:  return {6'b0, m_gate, 1'b0};
            A_STAT:  return m_stat;
            A_ENAB:  return m_en;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_accb = 0; m_accl = 0; m_prevb = 0; m_prevl = 0;
        m_rur = 0; m_gate = 0; m_irq = 0; m_stat = 0; m_en = 0;
    endtask

    // One bus/line cycle: drive at negedge, check read data, pass the edge, update model, check irq.
    task automatic cycle(input logic tk, input logic b, input logic l, input logic w,
                         input logic r, input logic [15:0] a, input logic [7:0] d,
                         input string req, input logic chk_rd, output logic [7:0] got);
        logic lb, ll, cb, cl;
        logic [7:0] clr;
        frame_tick = tk; bpv_evt = b; los_evt = l; cpu_wr = w; cpu_rd = r;
        cpu_addr = a; cpu_wdata = d;
        #1;
        got = cpu_rdata;
        if (r && chk_rd) check(req, cpu_rdata, rd_model(a));
        @(negedge clk);
        m_irq = m_gate & (|(m_stat & m_en));
        lb = m_accb | b; ll = m_accl | l; cb = 0; cl = 0;
        if (tk) begin
            cb = lb ^ m_prevb; cl = ll ^ m_prevl;
            m_prevb = lb; m_prevl = ll; m_accb = 0; m_accl = 0;
        end else begin
            m_accb = lb; m_accl = ll;
        end
        clr = 8'h00;
        if (w && a == A_STAT && !m_rur) clr = d & 8'h18;
        if (r && a == A_STAT && m_rur)  clr = m_stat;
        m_stat = (m_stat & ~clr) | {3'b0, cl, cb, 3'b0};
        if (w && a == A_CTRL) m_rur  = d[0];
        if (w && a == A_GATE) m_gate = d[1];
        if (w && a == A_ENAB) m_en   = d & 8'h18;
        check("R4 irq", {7'b0, irq}, {7'b0, m_irq});
    endtask

    logic [7:0] dmy;
    task automatic idle();                 cycle(0,0,0,0,0,16'h0,8'h0,"",0,dmy); endtask
    task automatic frm(input logic b, input logic l); cycle(1,b,l,0,0,16'h0,8'h0,"",0,dmy); endtask
    task automatic wr(input logic [15:0] a, input logic [7:0] d); cycle(0,0,0,1,0,a,d,"",0,dmy); endtask
    task automatic rd(input logic [15:0] a, input string req); cycle(0,0,0,0,1,a,8'h0,req,1,dmy); endtask

    task automatic do_reset();
        frame_tick = 0; bpv_evt = 0; los_evt = 0; cpu_wr = 0; cpu_rd = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        model_reset();
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        rst_n = 1;
    endtask

    // Vector: {wr, rd, addr[15:0], wdata[7:0], expected rdata[7:0]}
    localparam int NV = 16;
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 1'b1, 16'h0B00, 8'h00, 8'h00},  // R1 control
        {1'b0, 1'b1, 16'h0B01, 8'h00, 8'h00},  // R1 gate
        {1'b0, 1'b1, 16'h0B02, 8'h00, 8'h00},  // R1 status
        {1'b0, 1'b1, 16'h0B03, 8'h00, 8'h00},  // R1 enables
        {1'b1, 1'b0, 16'h0B03, 8'hFF, 8'h00},
        {1'b0, 1'b1, 16'h0B03, 8'h00, 8'h18},  // R8 unimplemented enable bits
        {1'b1, 1'b0, 16'h0B01, 8'hFF, 8'h00},
        {1'b0, 1'b1, 16'h0B01, 8'h00, 8'h02},  // R8 gate bit only
        {1'b1, 1'b0, 16'h0B00, 8'hFF, 8'h00},
        {1'b0, 1'b1, 16'h0B00, 8'h00, 8'h01},  // R8 control bit only
        {1'b1, 1'b0, 16'h0B00, 8'h00, 8'h00},
        {1'b1, 1'b0, 16'h0B07, 8'hFF, 8'h00},
        {1'b0, 1'b1, 16'h0B07, 8'h00, 8'h00},  // R8 unmapped read
        {1'b0, 1'b1, 16'h0B00, 8'h00, 8'h00},  // R8 unmapped write no effect
        {1'b0, 1'b1, 16'h0B03, 8'h00, 8'h18},  // R8 unmapped write no effect
        {1'b0, 1'b1, 16'h0AFF, 8'h00, 8'h00}   // R9 same-cycle read data
    };

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        model_reset();
        @(negedge clk);
        do_reset();
        for (int k = 0; k < NV; k++) begin
            cycle(0, 0, 0, VEC[k][33], VEC[k][32], VEC[k][31:16], VEC[k][15:8],
                  "", 0, got);
            if (VEC[k][32]) check("R1/R8/R9 vector", got, VEC[k][7:0]);
        end
        // R2: rising bipolar alarm on the tick cycle
        frm(1, 0); idle(); idle(); rd(A_STAT, "R2 rise");
        // R5: write 0 keeps, write 1 clears
        wr(A_STAT, 8'h00); rd(A_STAT, "R5 write zero keeps");
        wr(A_STAT, 8'h08); rd(A_STAT, "R5 write one clears"); idle();
        // R2: falling alarm also latches; steady level does not
        frm(0, 0); rd(A_STAT, "R2 fall"); wr(A_STAT, 8'h08);
        frm(0, 0); rd(A_STAT, "R2 no change");
        // R2: event mid-frame counts at the tick
        cycle(0, 1, 0, 0, 0, 16'h0, 8'h0, "", 0, got); idle();
        frm(0, 0); rd(A_STAT, "R2 mid-frame event"); wr(A_STAT, 8'h18);
        // R3: gate closed, status still latches
        wr(A_GATE, 8'h00); frm(0, 1); rd(A_STAT, "R3 latch while gated");
        idle(); wr(A_GATE, 8'h02); idle(); idle();
        // R4: per-source enable masks loss of signal
        wr(A_ENAB, 8'h08); wr(A_STAT, 8'h18); frm(0, 0);
        rd(A_STAT, "R4 los masked"); idle(); wr(A_ENAB, 8'h18); idle(); idle();
        wr(A_STAT, 8'hFF); idle();
        // R7: change and write-clear in the same cycle
        cycle(1, 1, 0, 1, 0, A_STAT, 8'h08, "", 0, got);
        rd(A_STAT, "R7 set beats write clear");
        // R6: clear on read, writes ignored
        wr(A_CTRL, 8'h01); wr(A_STAT, 8'hFF); rd(A_STAT, "R6 write ignored");
        rd(A_STAT, "R6 cleared by read");
        frm(0, 0); cycle(1, 0, 1, 0, 1, A_STAT, 8'h0, "R6 read returns", 1, got);
        rd(A_STAT, "R7 set beats read clear"); rd(A_STAT, "R6 empty");
        // R1: reset mid-run with pending status
        frm(1, 0); idle(); do_reset();
        rd(A_CTRL, "R1 ctrl"); rd(A_GATE, "R1 gate"); rd(A_STAT, "R1 stat"); rd(A_ENAB, "R1 en");
        idle();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule